// File: doc/BRIEF.md
# Range-Checked Synchronous Memory

A single-port word memory whose behaviour is all evaluated on the rising clock edge. A master presents a read strobe, a write strobe, a full-width address and write data. One cycle later the block returns the read word and an acknowledge flag. The depth is a compile-time parameter and may be much smaller than the address space the master uses. For that reason the whole address is compared against the depth on every access. Requests that fall outside the storage are refused: the acknowledge stays low, nothing is written and the read port keeps its previous word.

Reset clears every entry to zero, so a location that was never written reads as zero. Apart from the storage array and the output register, the block holds no state. A request that asserts both strobes on one cycle is a read-modify-write. It returns the word as it stood before the write and stores the new data in the same edge.

Top module: `rcm_mem`

## Requirements
- R1: While reset is high and on the first cycle after it, `ack` is 0 and `rd_data` is 0. Every entry reads as 0 until written.
- R2: An address is in range only when the full `ADDR_W`-bit value is below `DEPTH`. Addresses whose low bits alias a real entry but whose upper bits are set are out of range.
- R3: A read (`rd_en`=1, `wr_en`=0) to an in-range address puts the addressed word on `rd_data` in the cycle after the request.
- R4: A write (`wr_en`=1) to an in-range address stores `wr_data` at that address, and later reads return it.
- R5: An out-of-range read leaves `rd_data` at its previous value and gives `ack` 0 in the following cycle.
- R6: An out-of-range write changes no entry. The entry whose index equals the address's low bits keeps its old contents.
- R7: In the cycle after a request with neither strobe, `ack` is 0 and `rd_data` holds. A write without a read also leaves `rd_data` unchanged.
- R8: With both strobes high on an in-range address, `rd_data` returns the contents before the write, and the new data is stored.
- R9: `ack` is 1 exactly in the cycle following an in-range request with at least one strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears storage and outputs |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (32) | Word address, compared in full against DEPTH |
| wr_data | input | DATA_W (32) | Word to store |
| rd_data | output | DATA_W (32) | Registered read word |
| ack | output | 1 | Registered in-range acknowledge for the previous cycle's request |

## Verification
The embedded properties take for granted that the strobes and the address are known, non-X values on every sampled edge. They also assume that reset is held long enough for the clearing loop to run once. The bench changes inputs only on the falling edge and drives 0 on both strobes throughout reset. It drives every address as a defined 32-bit value, including values far beyond the depth, with aliasing low bits. The bench builds the memory with a depth that is not a power of two, so the magnitude comparison is exercised at its exact boundary.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

   localparam int RCM_WORD_W = 32;
   localparam int RCM_ADDR_W = 32;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'b00,
      ACC_READ  = 2'b01,
      ACC_WRITE = 2'b10,
      ACC_RMW   = 2'b11
   } acc_kind_e;

   function automatic acc_kind_e acc_decode(input logic rd, input logic wr);
      return acc_kind_e'({wr, rd});
   endfunction

   function automatic logic acc_reads(input acc_kind_e k);
      return (k == ACC_READ) || (k == ACC_RMW);
   endfunction

   function automatic logic acc_writes(input acc_kind_e k);
      return (k == ACC_WRITE) || (k == ACC_RMW);
   endfunction

endpackage

// File: rtl/rcm_range_chk.sv
module rcm_range_chk #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              in_range_o
);

   localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit IS_POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 1) begin : g_bad_depth
      $error("rcm_range_chk: DEPTH must be at least 1");
   end
   if (ADDR_W < 31 && DEPTH > (1 << ADDR_W)) begin : g_bad_span
      $error("rcm_range_chk: DEPTH exceeds the address space");
   end

   if (IS_POW2 && IDX_W < ADDR_W) begin : g_pow2
      // power-of-two depth: valid when every bit above the index is clear
      assign in_range_o = ~|addr_i[ADDR_W-1:IDX_W];
   end else if (IS_POW2) begin : g_full
      assign in_range_o = 1'b1;
   end else begin : g_cmp
      localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);
      assign in_range_o = ({1'b0, addr_i} < LIMIT);
   end

endmodule

// File: rtl/rcm_store.sv
module rcm_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   if (IDX_W < 1) begin : g_bad_idx
      $error("rcm_store: IDX_W must be at least 1");
   end

   logic [DATA_W-1:0] cells [DEPTH];
   logic              idx_ok;

   assign idx_ok  = (int'(idx_i) < DEPTH);
   assign rdata_o = idx_ok ? cells[idx_i] : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            cells[i] <= '0;
         end
      end else if (we_i && idx_ok) begin
         cells[idx_i] <= wdata_i;
      end
   end

   AST_WR_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
      we_i |-> (int'(idx_i) < DEPTH)); // R6

endmodule

// File: rtl/rcm_resp.sv
module rcm_resp #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ack_set_i,
   input  logic              rd_fire_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              ack_o,
   output logic [DATA_W-1:0] rd_data_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_o     <= 1'b0;
         rd_data_o <= '0;
      end else begin
         ack_o <= ack_set_i;
         if (rd_fire_i) begin
            rd_data_o <= rdata_i;
         end
      end
   end

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(rd_fire_i) |-> $stable(rd_data_o)); // R5

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      (ack_o && !$past(ack_set_i)) |-> 1'b0); // R9

endmodule

// File: rtl/rcm_mem.sv
module rcm_mem
   import rcm_pkg::*;
#(
   parameter int DATA_W = RCM_WORD_W,
   parameter int ADDR_W = RCM_ADDR_W,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              ack
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

   if (DATA_W < 1) begin : g_bad_width
      $error("rcm_mem: DATA_W must be at least 1");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("rcm_mem: ADDR_W too narrow for DEPTH");
   end

   acc_kind_e         kind;
   logic              in_range;
   logic              rd_fire;
   logic              wr_fire;
   logic              ack_set;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] cell_word;

   assign kind    = acc_decode(rd_en, wr_en);
   assign idx     = addr[IDX_W-1:0];
   assign rd_fire = in_range && acc_reads(kind);
   assign wr_fire = in_range && acc_writes(kind);
   assign ack_set = in_range && (kind != ACC_IDLE);

   rcm_range_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
      .addr_i     (addr),
      .in_range_o (in_range)
   );

   rcm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst     (rst),
      .we_i    (wr_fire),
      .idx_i   (idx),
      .wdata_i (wr_data),
      .rdata_o (cell_word)
   );

   rcm_resp #(.DATA_W(DATA_W)) u_resp (
      .clk       (clk),
      .rst       (rst),
      .ack_set_i (ack_set),
      .rd_fire_i (rd_fire),
      .rdata_i   (cell_word),
      .ack_o     (ack),
      .rd_data_o (rd_data)
   );

   AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      ack |-> ({1'b0, $past(addr)} < LIMIT)); // R2

   AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rd_en) && !$past(wr_en)) |-> !ack); // R7

   AST_ACK_VALID: assert property (@(posedge clk) disable iff (rst)
      (($past(rd_en) || $past(wr_en)) && ({1'b0, $past(addr)} < LIMIT)) |-> ack); // R9

   AST_WRITE_ONLY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rd_en)) |-> $stable(rd_data)); // R7

endmodule

// File: tb/sim_rcm_mem.sv
module sim_rcm_mem;

   localparam int DEPTH = 12;
   localparam int TCLK  = 20;

   typedef struct {
      logic        ack;
      logic [31:0] dout;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        ack;

   int vectors = 0;
   int miscompares = 0;

   exp_t        sb[$];
   logic [31:0] model [DEPTH];
   logic [31:0] exp_dout = '0;

   always #(TCLK / 2) clk = ~clk;

   rcm_mem #(.DEPTH(DEPTH)) u0 (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .ack     (ack)
   );

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // driver: one request per cycle, expected response pushed to the scoreboard
   task automatic step(input logic r, input logic w, input logic [31:0] a,
                       input logic [31:0] d, input string tag);
      exp_t e;
      logic ok;
      @(negedge clk);
      rd_en   = r;
      wr_en   = w;
      addr    = a;
      wr_data = d;
      ok = (a < 32'(DEPTH));
      if (r && ok) exp_dout = model[a];
      if (w && ok) model[a] = d;
      e.ack  = (r || w) && ok;
      e.dout = exp_dout;
      e.tag  = tag;
      sb.push_back(e);
   endtask

   // monitor: sample shortly after each rising edge and compare
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if (ack !== e.ack || rd_data !== e.dout) begin
               miscompares++;
               $display("FAIL %s: ack=%b data=%h expected ack=%b data=%h",
                        e.tag, ack, rd_data, e.ack, e.dout);
            end
         end
      end
   end

   initial begin
      #(200000 * TCLK);
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      vectors++;
      if (ack !== 1'b0 || rd_data !== 32'h0) begin
         miscompares++;
         $display("FAIL R1 in reset: ack=%b data=%h expected ack=0 data=0", ack, rd_data);
      end
      rst = 1'b0;

      step(0, 0, 0, 0, "R1 first idle");
      for (int i = 0; i < DEPTH; i++) step(1, 0, 32'(i), 0, "R1 cleared entry");

      for (int i = 0; i < DEPTH; i++)
         step(0, 1, 32'(i), 32'hA500_0000 ^ (32'(i) * 32'h0101_0101), "R4 write");
      for (int i = DEPTH - 1; i >= 0; i--) step(1, 0, 32'(i), 0, "R3 read back");

      step(1, 0, 32'(DEPTH), 0, "R2 read at depth");
      step(1, 0, 32'(DEPTH - 1), 0, "R2 read last entry");
      step(1, 0, 32'h0001_0003, 0, "R2 aliased high bits");
      step(1, 0, 32'hFFFF_FFFF, 0, "R5 read all ones");
      step(1, 0, 32'd15, 0, "R5 read past depth");

      step(0, 1, 32'h8000_0002, 32'hDEAD_BEEF, "R6 write aliased");
      step(0, 1, 32'(DEPTH), 32'h1234_5678, "R6 write at depth");
      step(1, 0, 32'd2, 0, "R6 entry 2 intact");
      step(1, 0, 32'd0, 0, "R6 entry 0 intact");

      step(0, 0, 32'd5, 32'hFFFF_0000, "R7 idle");
      step(0, 0, 32'd7, 0, "R7 idle again");
      step(0, 1, 32'd5, 32'h0BAD_F00D, "R7 write only holds data");
      step(1, 0, 32'd5, 0, "R4 new value");

      step(1, 1, 32'd9, 32'h9999_0009, "R8 read-modify-write old");
      step(1, 1, 32'd9, 32'h7777_0009, "R8 second rmw");
      step(1, 0, 32'd9, 0, "R8 stored value");
      step(1, 1, 32'h4000_0009, 32'h1, "R8 rmw out of range");
      step(1, 0, 32'd9, 0, "R6 rmw refused");

      step(1, 0, 32'd3, 0, "R9 back to back a");
      step(1, 0, 32'd4, 0, "R9 back to back b");
      step(0, 0, 32'd4, 0, "R9 ack drops");
      step(0, 0, 0, 0, "R7 final idle");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule